// File: doc/BRIEF.md
# Maskable BCD Real-Time-Clock Alarm

This block watches a running real-time clock whose seconds, minutes, hours, weekday and date arrive as BCD bytes. It holds four alarm bytes: seconds, minutes, hours and day. On every one-second strobe it checks whether the current time satisfies every alarm field that is not masked. When the time satisfies them, a sticky alarm flag is set. The flag drives an active-low alarm pin, and that pin is merged with an active-low input from other alarm sources.

Each alarm byte carries its own mask bit. The day byte also carries a selector that picks between weekday and day-of-month matching. As a result, one comparator covers every periodic alarm from once per second to once per month. The hours field keeps the clock's own 12/24-hour layout. Both alarm and clock hours are reduced to a time of day before they are compared, so a 12-hour alarm can match a 24-hour clock. Software clears the flag by writing the status register. A register-protection input blocks that clear and also blocks writes to the alarm bytes.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, `alarm_flag` is 0, every alarm byte holds 8'h00, and `alarm_n` is 1 while `shared_in_n` is 1.
- R2: An alarm is detected when the strobe is high, both enables are high and every unmasked field matches. `alarm_flag` is 1 from the clock edge that samples the strobe onward.
- R3: Bit 7 of each alarm byte is a mask, and a 1 removes that field from the match. With all four masks set, every strobe sets the flag.
- R4: Bit 6 of the day byte selects the comparison. A 1 compares bits 5:0 with the BCD weekday (coded 1 to 7), and a 0 compares them with the BCD date.
- R5: Hours bytes, for both alarm and clock, use bit 6 as the format. In 1 = 12-hour format, bit 5 is PM and bits 4:0 hold BCD 01 to 12. In 0 = 24-hour format, bits 5:0 hold BCD 00 to 23. Hours match when both bytes denote the same hour of day.
- R6: No alarm is detected unless `osc_en` and `alm_en` are both 1.
- R7: A match without the strobe does not set the flag.
- R8: `alarm_flag` stays set until a cycle with `stat_clr`=1 and `reg_lock`=0 clears it. A clear while `reg_lock`=1 is ignored.
- R9: A write to an alarm byte while `reg_lock`=1 is ignored.
- R10: `alarm_n` is 0 exactly when `alarm_flag` is 1 or `shared_in_n` is 0.
- R11: If a detection and a permitted clear fall in the same cycle, the flag ends up set.
- R12: `wr_sel` addresses 0 = seconds, 1 = minutes, 2 = hours, 3 = day. A write changes only the selected byte, and the new value is used from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1s | input | 1 | One-cycle strobe per second |
| osc_en | input | 1 | Oscillator running |
| alm_en | input | 1 | Clock alarm enabled |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, 12/24 layout |
| cur_wday | input | 8 | Current weekday, 1 to 7 |
| cur_date | input | 8 | Current day of month, BCD |
| wr_en | input | 1 | Alarm byte write strobe |
| wr_sel | input | 2 | Alarm byte select |
| wr_data | input | 8 | Alarm byte write data |
| reg_lock | input | 1 | Register protection |
| stat_clr | input | 1 | Status register write (clear) |
| shared_in_n | input | 1 | Other alarm sources, active low |
| alarm_flag | output | 1 | Sticky clock-alarm status |
| alarm_n | output | 1 | Shared active-low alarm pin |

## Verification
The bench builds the block with the default reset value of 8'h00 for the alarm bytes. With that value an unprogrammed alarm can never fire, because its date field of 00 never matches a real date. This makes the reset state observable at the pin. The random stimulus mixes masks, day selectors and hour formats independently on the alarm side and the clock side. This brings cross-format hour matches, such as midnight and noon written in 12-hour form, within reach alongside the directed protection and same-cycle set/clear cases.

// File: rtl/rtc_alarm_pkg.sv
// Shared constants and BCD helpers for the clock alarm.
// Assumes inputs are well-formed BCD bytes in the clock layout.
package rtc_alarm_pkg;
    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 4;
    localparam int SEL_W      = $clog2(NUM_FIELDS);
    localparam int MASK_BIT   = FIELD_W - 1;
    localparam int DSEL_BIT   = 6;
    localparam int HFMT_BIT   = 6;
    localparam int PM_BIT     = 5;

    typedef enum logic [SEL_W-1:0] {
        FLD_SEC  = 2'd0,
        FLD_MIN  = 2'd1,
        FLD_HOUR = 2'd2,
        FLD_DAY  = 2'd3
    } field_e;

    // Reduce an hours byte in either format to hour of day 0..23.
    function automatic logic [4:0] hour_of_day(input logic [FIELD_W-1:0] h);
        logic [4:0] hr;
        if (h[HFMT_BIT]) begin
            hr = 5'(h[4]) * 5'd10 + 5'(h[3:0]);
            if (hr == 5'd12) hr = 5'd0;
            if (h[PM_BIT]) hr = hr + 5'd12;
        end else begin
            hr = 5'(h[5:4]) * 5'd10 + 5'(h[3:0]);
        end
        return hr;
    endfunction
endpackage

// File: rtl/rtc_alarm_regs.sv
// Bank of alarm bytes written one at a time through a select port.
// Assumes wr_sel is one of the field codes; writes are blocked by lock.
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
#(
    parameter logic [FIELD_W-1:0] RST_VAL = '0
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [SEL_W-1:0]                     wr_sel,
    input  logic [FIELD_W-1:0]                   wr_data,
    input  logic                                 lock,
    output logic [NUM_FIELDS-1:0][FIELD_W-1:0]   regs_q
);
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
        // Hold one alarm byte; load when addressed and unlocked.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[i] <= RST_VAL;
            else if (wr_en && !lock && (wr_sel == SEL_W'(i)))
                regs_q[i] <= wr_data;
        end
    end
endmodule

// File: rtl/rtc_alarm_cmp.sv
// Combinational match of the current time against the alarm bytes.
// A set mask bit forces its field to match; the day byte picks weekday
// or date; hours are compared as hour of day regardless of format.
module rtc_alarm_cmp
    import rtc_alarm_pkg::*;
(
    input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] regs,
    input  logic [FIELD_W-1:0]                 cur_sec,
    input  logic [FIELD_W-1:0]                 cur_min,
    input  logic [FIELD_W-1:0]                 cur_hour,
    input  logic [FIELD_W-1:0]                 cur_wday,
    input  logic [FIELD_W-1:0]                 cur_date,
    output logic                               hit
);
    logic [NUM_FIELDS-1:0] eq;
    logic [NUM_FIELDS-1:0] ok;

    // Per-field equality on the value bits.
    always_comb begin
        eq[FLD_SEC]  = (regs[FLD_SEC][6:0] == cur_sec[6:0]);
        eq[FLD_MIN]  = (regs[FLD_MIN][6:0] == cur_min[6:0]);
        eq[FLD_HOUR] = (hour_of_day(regs[FLD_HOUR]) == hour_of_day(cur_hour));
        eq[FLD_DAY]  = regs[FLD_DAY][DSEL_BIT] ? (regs[FLD_DAY][5:0] == cur_wday[5:0])
                                              : (regs[FLD_DAY][5:0] == cur_date[5:0]);
    end

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_ok
        assign ok[i] = regs[i][MASK_BIT] | eq[i];
    end

    assign hit = &ok;
endmodule

// File: rtl/rtc_alarm_flag.sv
// Sticky alarm status. Detection has priority over a clear.
module rtc_alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic clr,
    input  logic lock,
    output logic flag_q
);
    // Set on detection, clear on an unlocked status write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (fire)
            flag_q <= 1'b1;
        else if (clr && !lock)
            flag_q <= 1'b0;
    end
endmodule

// File: rtl/rtc_alarm_match.sv
// Top of the maskable clock alarm: alarm bytes, comparator, sticky flag
// and a shared active-low pin. Assumes tick_1s is one cycle wide.
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter logic [7:0] ALM_RST_VAL = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1s,
    input  logic       osc_en,
    input  logic       alm_en,
    input  logic [7:0] cur_sec,
    input  logic [7:0] cur_min,
    input  logic [7:0] cur_hour,
    input  logic [7:0] cur_wday,
    input  logic [7:0] cur_date,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic       reg_lock,
    input  logic       stat_clr,
    input  logic       shared_in_n,
    output logic       alarm_flag,
    output logic       alarm_n
);
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] alm_regs;
    logic                               hit;
    logic                               fire;

    rtc_alarm_regs #(.RST_VAL(ALM_RST_VAL)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .lock(reg_lock), .regs_q(alm_regs)
    );

    rtc_alarm_cmp u_cmp (
        .regs(alm_regs), .cur_sec(cur_sec), .cur_min(cur_min),
        .cur_hour(cur_hour), .cur_wday(cur_wday), .cur_date(cur_date),
        .hit(hit)
    );

    // Qualify the match with the strobe and both enables.
    assign fire = tick_1s & osc_en & alm_en & hit;

    rtc_alarm_flag u_flag (
        .clk(clk), .rst_n(rst_n), .fire(fire), .clr(stat_clr),
        .lock(reg_lock), .flag_q(alarm_flag)
    );

    // Wired-AND of this alarm with the other sources on the pin.
    assign alarm_n = ~alarm_flag & shared_in_n;
endmodule

// File: rtl/rtc_alarm_match_chk.sv
// Protocol checker for rtc_alarm_match, attached by bind.
module rtc_alarm_match_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_1s,
    input logic        osc_en,
    input logic        alm_en,
    input logic        hit,
    input logic        reg_lock,
    input logic        stat_clr,
    input logic        alarm_flag,
    input logic        alarm_n,
    input logic [31:0] regs_flat
);
    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1s && osc_en && alm_en && hit) |=> alarm_flag);

    p_no_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_flag && !tick_1s) |=> !alarm_flag);

    p_enables_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_flag && !(osc_en && alm_en)) |=> !alarm_flag);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !(stat_clr && !reg_lock)) |=> alarm_flag);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !reg_lock && !(tick_1s && osc_en && alm_en && hit)) |=> !alarm_flag);

    p_lock_regs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_lock |=> $stable(regs_flat));

    p_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_flag |-> !alarm_n);
endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .osc_en(osc_en),
    .alm_en(alm_en), .hit(hit), .reg_lock(reg_lock), .stat_clr(stat_clr),
    .alarm_flag(alarm_flag), .alarm_n(alarm_n), .regs_flat(alm_regs)
);

// File: tb/rtc_alarm_match_tb.sv
`timescale 1ns/1ps
module rtc_alarm_match_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1s = 1'b0, osc_en = 1'b0, alm_en = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_wday = 8'h01, cur_date = 8'h01;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       reg_lock = 1'b0, stat_clr = 1'b0, shared_in_n = 1'b1;
    logic       alarm_flag, alarm_n;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rtc_alarm_match u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .osc_en(osc_en), .alm_en(alm_en),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_wday(cur_wday), .cur_date(cur_date), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .reg_lock(reg_lock), .stat_clr(stat_clr),
        .shared_in_n(shared_in_n), .alarm_flag(alarm_flag), .alarm_n(alarm_n)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    // Encode hour of day 0..23 in the requested format.
    function automatic logic [7:0] enc_hour(input int h, input bit fmt12);
        int h12;
        if (!fmt12) return bcd(h);
        h12 = h % 12;
        if (h12 == 0) h12 = 12;
        return {1'b0, 1'b1, (h >= 12) ? 1'b1 : 1'b0, bcd(h12)[4:0]};
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); tick_1s = 1'b1;
        @(negedge clk); tick_1s = 1'b0;
    endtask

    task automatic clr();
        @(negedge clk); stat_clr = 1'b1;
        @(negedge clk); stat_clr = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int a_s, a_m, a_h, a_w, a_d, c_s, c_m, c_h, c_w, c_d;
        bit m_s, m_m, m_h, m_d, dsel, af12, cf12, en;
        logic exp;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state; the 00 date byte never matches a real date
        check("R1 flag", alarm_flag, 1'b0);
        check("R1 pin", alarm_n, 1'b1);
        osc_en = 1'b1; alm_en = 1'b1;
        tick();
        check("R1 reset bytes do not match", alarm_flag, 1'b0);

        // R3: all masked fires on every strobe
        wr(2'd0, 8'h80); wr(2'd1, 8'h80); wr(2'd2, 8'h80); wr(2'd3, 8'h80);
        for (int k = 0; k < 3; k++) begin
            cur_sec = bcd(k * 7);
            tick();
            check("R3 all masked", alarm_flag, 1'b1);
            clr();
            check("R8 clear", alarm_flag, 1'b0);
        end

        // R10: pin follows the flag and the shared input
        shared_in_n = 1'b0; #1;
        check("R10 shared low", alarm_n, 1'b0);
        shared_in_n = 1'b1; #1;
        check("R10 idle high", alarm_n, 1'b1);

        // R7: no strobe, no set
        repeat (3) @(negedge clk);
        check("R7 no strobe", alarm_flag, 1'b0);

        // R6: either enable low blocks detection
        osc_en = 1'b0; tick();
        check("R6 osc off", alarm_flag, 1'b0);
        osc_en = 1'b1; alm_en = 1'b0; tick();
        check("R6 alarm off", alarm_flag, 1'b0);
        alm_en = 1'b1;

        // R8: locked clear ignored, sticky across cycles
        tick();
        check("R10 pin low on flag", alarm_n, 1'b0);
        reg_lock = 1'b1; clr();
        check("R8 locked clear", alarm_flag, 1'b1);
        reg_lock = 1'b0; repeat (2) @(negedge clk);
        check("R8 sticky", alarm_flag, 1'b1);

        // R11: set and clear together leaves flag set
        @(negedge clk); tick_1s = 1'b1; stat_clr = 1'b1;
        @(negedge clk); tick_1s = 1'b0; stat_clr = 1'b0;
        check("R11 set wins", alarm_flag, 1'b1);
        clr();

        // R9: locked write to seconds is ignored (still masked)
        reg_lock = 1'b1; wr(2'd0, 8'h59); reg_lock = 1'b0;
        cur_sec = 8'h10; tick();
        check("R9 locked write ignored", alarm_flag, 1'b1);
        clr();

        // R12: write seconds only; other fields stay masked
        wr(2'd0, 8'h42);
        cur_sec = 8'h41; tick();
        check("R12 seconds mismatch", alarm_flag, 1'b0);
        cur_sec = 8'h42; tick();
        check("R12 seconds match", alarm_flag, 1'b1);
        clr();

        // R5: 12-hour 12 AM alarm vs 24-hour 00; 12 PM vs 12
        wr(2'd0, 8'h80); wr(2'd2, 8'h52);
        cur_hour = 8'h00; tick();
        check("R5 12AM vs 00", alarm_flag, 1'b1);
        clr();
        cur_hour = 8'h12; tick();
        check("R5 12AM vs 12", alarm_flag, 1'b0);
        wr(2'd2, 8'h72); tick();
        check("R5 12PM vs 12", alarm_flag, 1'b1);
        clr();
        wr(2'd2, 8'h80);

        // R4: weekday vs date selection
        wr(2'd3, 8'h43); cur_wday = 8'h03; cur_date = 8'h05; tick();
        check("R4 weekday match", alarm_flag, 1'b1);
        clr();
        wr(2'd3, 8'h03); tick();
        check("R4 date mismatch", alarm_flag, 1'b0);
        cur_date = 8'h03; tick();
        check("R4 date match", alarm_flag, 1'b1);
        clr();

        // R2..R5: random fields, masks and formats
        for (int it = 0; it < 400; it++) begin
            a_s = $urandom % 60; a_m = $urandom % 60; a_h = $urandom % 24;
            a_w = 1 + $urandom % 7; a_d = 1 + $urandom % 31;
            m_s = ($urandom % 4) == 0; m_m = ($urandom % 4) == 0;
            m_h = ($urandom % 4) == 0; m_d = ($urandom % 4) == 0;
            dsel = $urandom % 2; af12 = $urandom % 2; cf12 = $urandom % 2;
            c_s = ($urandom % 3 != 0) ? a_s : $urandom % 60;
            c_m = ($urandom % 3 != 0) ? a_m : $urandom % 60;
            c_h = ($urandom % 3 != 0) ? a_h : $urandom % 24;
            c_w = ($urandom % 3 != 0) ? a_w : 1 + $urandom % 7;
            c_d = ($urandom % 3 != 0) ? a_d : 1 + $urandom % 31;
            en = ($urandom % 5) != 0;
            wr(2'd0, {m_s, bcd(a_s)[6:0]});
            wr(2'd1, {m_m, bcd(a_m)[6:0]});
            wr(2'd2, {m_h, enc_hour(a_h, af12)[6:0]});
            wr(2'd3, {m_d, dsel, dsel ? bcd(a_w)[5:0] : bcd(a_d)[5:0]});
            cur_sec = bcd(c_s); cur_min = bcd(c_m); cur_hour = enc_hour(c_h, cf12);
            cur_wday = bcd(c_w); cur_date = bcd(c_d);
            osc_en = en; alm_en = en | ($urandom % 2);
            exp = osc_en && alm_en && (m_s || a_s == c_s) && (m_m || a_m == c_m)
                  && (m_h || a_h == c_h) && (m_d || (dsel ? a_w == c_w : a_d == c_d));
            tick();
            check("R2 random match", alarm_flag, exp);
            clr();
            check("R8 random clear", alarm_flag, 1'b0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule